// File: doc/BRIEF.md
# Wrapped-Key Encryption Request Sequencer

This block runs one encryption request at a time. The request does not carry a raw key. It carries a 512-bit wrapped key handle, together with a 128-bit data block, the requester's privilege level and three gating inputs: a feature-enable bit, a lock-prefix indicator and a task-switched bit.

The sequencer first screens the gating inputs, which can raise one of two faults. It then checks that the handle is legal. A legal handle goes to an external unwrap-and-authenticate unit through a valid/ready handshake. If the unwrap unit returns an authentic 256-bit key, the sequencer hands that key and the data block to an external 14-round AES-256 engine through a second handshake. It then reports completion with a one-cycle done pulse, a failure flag and five auxiliary status flags. On success it also raises a write-enable for the encrypted block.

Each external unit, once it has accepted a request, reports its result with a one-cycle done strobe. The handle layout uses these bit positions: bit 0 is a privileged-only marker, bit 1 is a forbidden bit, bits 27..2 are reserved, and bits 31..28 hold the key-type field, whose AES-256 code is 4'h2. The reserved mask, the field position and the code are all parameters.

Top module: `wkey_enc_seq`

## Requirements
- R1: A request is taken on a cycle where req_valid and req_ready are both high. req_ready is high only while the sequencer is idle, and it stays low from the cycle after acceptance until the completion pulse has passed.
- R2: If req_feat_en is 0 or req_lock is 1, the request completes with fault_ud=1. This takes priority over the task-switched check. No unwrap or encrypt is started, wr_en stays 0, and flag_fail and flags_other keep their previous values.
- R3: If R2 does not apply and req_ts is 1, the request completes with fault_nm=1 and has the same no-effect behaviour as R2.
- R4: A handle with any bit set under the reserved mask (default bits 27..2) completes with flag_fail=1. No unwrap is started.
- R5: A handle with bit 0 set is illegal when req_cpl is not 0, giving flag_fail=1 with no unwrap. With req_cpl equal to 0, bit 0 alone does not make the handle illegal.
- R6: A handle with bit 1 set completes with flag_fail=1. No unwrap is started.
- R7: A handle whose bits 31..28 are not 4'h2 completes with flag_fail=1. No unwrap is started.
- R8: For a legal handle, unw_valid rises and carries the whole 512-bit handle on unw_handle. Both hold steady until unw_ready is seen.
- R9: If the unwrap unit reports unw_auth=0, the request completes with flag_fail=1, no encrypt is started and wr_en stays 0.
- R10: If the unwrap unit reports unw_auth=1, aes_valid presents the recovered key and the data block. On completion, wr_en=1, wr_data equals the engine result and flag_fail=0.
- R11: Every completion without a fault drives flags_other (overflow, sign, aux-carry, parity, carry) to 0.
- R12: done is high for exactly one cycle per accepted request. wr_en and the fault outputs are only high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_handle | input | 512 | Wrapped key handle |
| req_data | input | 128 | Plaintext block |
| req_cpl | input | 2 | Requester privilege level |
| req_feat_en | input | 1 | Feature enabled |
| req_lock | input | 1 | Lock prefix present |
| req_ts | input | 1 | Task-switched bit |
| unw_valid | output | 1 | Unwrap request valid |
| unw_ready | input | 1 | Unwrap unit accepts request |
| unw_handle | output | 512 | Handle passed to unwrap unit |
| unw_done | input | 1 | Unwrap result strobe |
| unw_auth | input | 1 | Key authentic |
| unw_key | input | 256 | Recovered key |
| aes_valid | output | 1 | Encrypt request valid |
| aes_ready | input | 1 | Engine accepts request |
| aes_key | output | 256 | Key for engine |
| aes_data | output | 128 | Block for engine |
| aes_done | input | 1 | Engine result strobe |
| aes_result | input | 128 | Ciphertext |
| done | output | 1 | Completion pulse |
| fault_ud | output | 1 | Undefined-operation fault |
| fault_nm | output | 1 | Device-not-available fault |
| flag_fail | output | 1 | Handle or authentication failure |
| flags_other | output | 5 | Auxiliary status flags |
| wr_en | output | 1 | Write result back |
| wr_data | output | 128 | Result to write |

## Verification
The assertions check on every cycle the handshake rules that must hold whatever the stimulus. Each valid holds, with a stable payload, until its ready arrives. The done pulse is one cycle long. A fault completion never writes and never moves the flags, and every non-fault completion clears the auxiliary flags. Other behaviours depend on the request and can only be shown by the bench's scenarios. These are the legality decision for each handle rule, the privilege exception for bit 0, the fault priority, whether the unwrap and encrypt units were started at all, and the ciphertext value. The bench runs a sequence of requests through the modelled unwrap and engine units and compares each completion with a queued expectation.

// File: rtl/wkey_pkg.sv
package wkey_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_UNWRAP,
    ST_ENCRYPT,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/wkey_fault_gate.sv
module wkey_fault_gate (
  input  logic feat_en,
  input  logic lock,
  input  logic ts,
  output logic ud,
  output logic nm
);
  // the undefined-operation fault outranks the task-switched fault
  always_comb begin
    ud = !feat_en || lock;
    nm = !ud && ts;
  end
endmodule

// File: rtl/wkey_handle_check.sv
module wkey_handle_check #(
  parameter int HW = 512,
  parameter int CW = 2,
  parameter logic [HW-1:0] RSVD_MASK = 512'h0FFF_FFFC,
  parameter int KT_LSB = 28,
  parameter int KT_W = 4,
  parameter logic [KT_W-1:0] KT_CODE = 4'h2
) (
  input  logic [HW-1:0] handle,
  input  logic [CW-1:0] cpl,
  output logic          illegal
);
  logic rsvd_hit, priv_hit, forbid_hit, type_bad;

  always_comb begin
    rsvd_hit   = |(handle & RSVD_MASK);
    priv_hit   = handle[0] && (cpl != '0);
    forbid_hit = handle[1];
    type_bad   = handle[KT_LSB +: KT_W] != KT_CODE;
    illegal    = rsvd_hit || priv_hit || forbid_hit || type_bad;
  end
endmodule

// File: rtl/wkey_enc_seq.sv
module wkey_enc_seq
  import wkey_pkg::*;
#(
  parameter int HW = 512,
  parameter int DW = 128,
  parameter int KW = 256,
  parameter int CW = 2,
  parameter int NFLAG = 5,
  parameter logic [HW-1:0] RSVD_MASK = 512'h0FFF_FFFC,
  parameter int KT_LSB = 28,
  parameter int KT_W = 4,
  parameter logic [KT_W-1:0] KT_CODE = 4'h2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [HW-1:0]    req_handle,
  input  logic [DW-1:0]    req_data,
  input  logic [CW-1:0]    req_cpl,
  input  logic             req_feat_en,
  input  logic             req_lock,
  input  logic             req_ts,
  output logic             unw_valid,
  input  logic             unw_ready,
  output logic [HW-1:0]    unw_handle,
  input  logic             unw_done,
  input  logic             unw_auth,
  input  logic [KW-1:0]    unw_key,
  output logic             aes_valid,
  input  logic             aes_ready,
  output logic [KW-1:0]    aes_key,
  output logic [DW-1:0]    aes_data,
  input  logic             aes_done,
  input  logic [DW-1:0]    aes_result,
  output logic             done,
  output logic             fault_ud,
  output logic             fault_nm,
  output logic             flag_fail,
  output logic [NFLAG-1:0] flags_other,
  output logic             wr_en,
  output logic [DW-1:0]    wr_data
);
  seq_state_t    state;
  logic          sent;
  logic [HW-1:0] h_q;
  logic [DW-1:0] d_q;
  logic [CW-1:0] cpl_q;
  logic          en_q, lock_q, ts_q;
  logic [KW-1:0] key_q;
  logic          g_ud, g_nm, illegal;

  wkey_fault_gate u_gate (
    .feat_en (en_q),
    .lock    (lock_q),
    .ts      (ts_q),
    .ud      (g_ud),
    .nm      (g_nm)
  );

  wkey_handle_check #(
    .HW(HW), .CW(CW), .RSVD_MASK(RSVD_MASK),
    .KT_LSB(KT_LSB), .KT_W(KT_W), .KT_CODE(KT_CODE)
  ) u_chk (
    .handle  (h_q),
    .cpl     (cpl_q),
    .illegal (illegal)
  );

  assign req_ready  = (state == ST_IDLE);
  assign unw_valid  = (state == ST_UNWRAP) && !sent;
  assign unw_handle = h_q;
  assign aes_valid  = (state == ST_ENCRYPT) && !sent;
  assign aes_key    = key_q;
  assign aes_data   = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sent        <= 1'b0;
      h_q         <= '0;
      d_q         <= '0;
      cpl_q       <= '0;
      en_q        <= 1'b0;
      lock_q      <= 1'b0;
      ts_q        <= 1'b0;
      key_q       <= '0;
      done        <= 1'b0;
      fault_ud    <= 1'b0;
      fault_nm    <= 1'b0;
      flag_fail   <= 1'b0;
      flags_other <= '0;
      wr_en       <= 1'b0;
      wr_data     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            h_q    <= req_handle;
            d_q    <= req_data;
            cpl_q  <= req_cpl;
            en_q   <= req_feat_en;
            lock_q <= req_lock;
            ts_q   <= req_ts;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          sent <= 1'b0;
          if (g_ud || g_nm) begin
            fault_ud <= g_ud;
            fault_nm <= g_nm;
            done     <= 1'b1;
            state    <= ST_DONE;
          end else if (illegal) begin
            flag_fail   <= 1'b1;
            flags_other <= '0;
            done        <= 1'b1;
            state       <= ST_DONE;
          end else begin
            state <= ST_UNWRAP;
          end
        end
        ST_UNWRAP: begin
          if (!sent && unw_ready) sent <= 1'b1;
          if (sent && unw_done) begin
            sent <= 1'b0;
            if (unw_auth) begin
              key_q <= unw_key;
              state <= ST_ENCRYPT;
            end else begin
              flag_fail   <= 1'b1;
              flags_other <= '0;
              done        <= 1'b1;
              state       <= ST_DONE;
            end
          end
        end
        ST_ENCRYPT: begin
          if (!sent && aes_ready) sent <= 1'b1;
          if (sent && aes_done) begin
            sent        <= 1'b0;
            wr_data     <= aes_result;
            wr_en       <= 1'b1;
            flag_fail   <= 1'b0;
            flags_other <= '0;
            done        <= 1'b1;
            state       <= ST_DONE;
          end
        end
        default: begin
          done     <= 1'b0;
          wr_en    <= 1'b0;
          fault_ud <= 1'b0;
          fault_nm <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: unwrap request and handle stay put until accepted
  p_unw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    unw_valid && !unw_ready |=> unw_valid && $stable(unw_handle));

  // R10: encrypt request and payload stay put until accepted
  p_aes_hold_r10: assert property (@(posedge clk) disable iff (rst)
    aes_valid && !aes_ready |=> aes_valid && $stable(aes_key) && $stable(aes_data));

  // R2, R3: a fault completion never writes and leaves the flags untouched
  p_fault_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    done && (fault_ud || fault_nm) |-> !wr_en && $stable(flag_fail) && $stable(flags_other));

  // R11: every non-fault completion clears the auxiliary flags
  p_other_clear_r11: assert property (@(posedge clk) disable iff (rst)
    done && !fault_ud && !fault_nm |-> flags_other == '0);

  // R1: nothing is offered downstream while a request can still be taken
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !unw_valid && !aes_valid);
endmodule

// File: tb/wkey_enc_seq_test.sv
module wkey_enc_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_ready;
  logic [511:0] req_handle = '0;
  logic [127:0] req_data = '0;
  logic [1:0]   req_cpl = '0;
  logic         req_feat_en = 1'b1, req_lock = 1'b0, req_ts = 1'b0;
  logic         unw_valid, unw_ready = 1'b0, unw_done = 1'b0, unw_auth = 1'b0;
  logic [511:0] unw_handle;
  logic [255:0] unw_key = '0;
  logic         aes_valid, aes_ready = 1'b0, aes_done = 1'b0;
  logic [255:0] aes_key;
  logic [127:0] aes_data, aes_result = '0;
  logic         done, fault_ud, fault_nm, flag_fail, wr_en;
  logic [4:0]   flags_other;
  logic [127:0] wr_data;

  wkey_enc_seq uut (.*);

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stub unwrap unit: key = upper half of handle, not authentic if top word is BAD0BAD0
  int us = 0;
  logic [511:0] uh;
  always @(negedge clk) begin
    unw_ready <= 1'b0;
    unw_done  <= 1'b0;
    if (rst) us <= 0;
    else if (us == 0) begin
      if (unw_valid) begin
        unw_ready <= 1'b1;
        uh <= unw_handle;
        us <= 1;
      end
    end else if (us == 3) begin
      unw_done <= 1'b1;
      unw_auth <= uh[511:480] != 32'hBAD0_BAD0;
      unw_key  <= uh[511:256];
      us <= 0;
    end else us <= us + 1;
  end

  // stub engine: result = data ^ key halves
  int as_ = 0;
  logic [127:0] ar;
  always @(negedge clk) begin
    aes_ready <= 1'b0;
    aes_done  <= 1'b0;
    if (rst) as_ <= 0;
    else if (as_ == 0) begin
      if (aes_valid) begin
        aes_ready <= 1'b1;
        ar <= aes_data ^ aes_key[127:0] ^ aes_key[255:128];
        as_ <= 1;
      end
    end else if (as_ == 4) begin
      aes_done   <= 1'b1;
      aes_result <= ar;
      as_ <= 0;
    end else as_ <= as_ + 1;
  end

  typedef struct {
    bit ud, nm, fail, wr, unw, aes;
    logic [127:0] data;
    string tag;
  } exp_t;
  exp_t q[$];
  bit unw_seen = 0, aes_seen = 0;
  bit pending = 0;
  bit last_fail = 0;

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (unw_valid) unw_seen = 1;
      if (aes_valid) aes_seen = 1;
      if (done) begin
        if (q.size() == 0) chk(0, "R12 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(fault_ud == e.ud, {e.tag, " fault_ud"}, fault_ud, e.ud);
          chk(fault_nm == e.nm, {e.tag, " fault_nm"}, fault_nm, e.nm);
          chk(flag_fail == e.fail, {e.tag, " flag_fail"}, flag_fail, e.fail);
          chk(wr_en == e.wr, {e.tag, " wr_en"}, wr_en, e.wr);
          chk(unw_seen == e.unw, {e.tag, " unwrap started"}, unw_seen, e.unw);
          chk(aes_seen == e.aes, {e.tag, " encrypt started"}, aes_seen, e.aes);
          if (!e.ud && !e.nm) chk(flags_other == 0, "R11 flags_other", flags_other, 0);
          if (e.wr) chk(wr_data == e.data, {e.tag, " wr_data"}, wr_data, e.data);
        end
        pending = 0;
      end
    end
  end

  function automatic logic [511:0] mk(input logic [255:0] hi, input bit b0, input bit b1);
    return {hi, 224'b0, 4'h2, 26'b0, b1, b0};
  endfunction

  task automatic send(input logic [511:0] h, input logic [127:0] d, input logic [1:0] cpl,
                      input bit en, input bit lk, input bit ts, input string tag);
    exp_t e;
    bit ud, nm, illegal, auth;
    ud = !en || lk;
    nm = !ud && ts;
    illegal = (|h[27:2]) || (h[0] && cpl != 0) || h[1] || (h[31:28] != 4'h2);
    auth = h[511:480] != 32'hBAD0_BAD0;
    e.tag = tag; e.ud = ud; e.nm = nm;
    e.unw = !ud && !nm && !illegal;
    e.aes = e.unw && auth;
    e.wr = e.aes;
    e.fail = (ud || nm) ? last_fail : !e.aes;
    e.data = d ^ h[383:256] ^ h[511:384];
    last_fail = e.fail;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready when idle", req_ready, 1);
    unw_seen = 0; aes_seen = 0;
    req_valid = 1; req_handle = h; req_data = d; req_cpl = cpl;
    req_feat_en = en; req_lock = lk; req_ts = ts;
    q.push_back(e);
    pending = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R1 busy after accept", req_ready, 0);
    while (pending) @(negedge clk);
    @(negedge clk);
    chk(done == 0 && wr_en == 0, "R12 done one cycle", {done, wr_en}, 0);
  endtask

  initial begin
    logic [255:0] k1, k2, kb;
    k1 = {64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h9999_AAAA_BBBB_CCCC};
    k2 = {64'hFEDC_BA98_7654_3210, 192'h0F0F_F0F0_1234_5678_9ABC_DEF0_0000_1111_2222_3333};
    kb = {32'hBAD0_BAD0, 224'h1234};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1 && done == 0 && wr_en == 0 && flag_fail == 0, "R1 reset state",
        {req_ready, done, wr_en, flag_fail}, 4'b1000);
    send(mk(k1, 0, 0), 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 0, 1, 0, 0, "R10 legal authentic");
    send(mk(k1, 0, 0) | 512'h40, 128'h1, 0, 1, 0, 0, "R4 reserved bit");
    send(mk(k1, 0, 0), 128'h2, 0, 1, 1, 0, "R2 lock prefix");
    send(mk(k1, 0, 0), 128'h3, 0, 1, 0, 1, "R3 task switched");
    send(mk(k2, 1, 0), 128'hCAFE, 0, 1, 0, 0, "R5 bit0 cpl0 legal");
    send(mk(k2, 1, 0), 128'h4, 3, 1, 0, 0, "R5 bit0 cpl3 illegal");
    send(mk(k2, 0, 0), 128'h5, 0, 1, 0, 0, "R8 legal again");
    send(mk(k2, 0, 1), 128'h6, 0, 1, 0, 0, "R6 bit1");
    send(mk(k2, 0, 0), 128'h7, 0, 0, 0, 1, "R2 disabled over ts");
    send(mk(k2, 0, 0) ^ (512'h3 << 28), 128'h8, 0, 1, 0, 0, "R7 key type");
    send(mk(kb, 0, 0), 128'h9, 0, 1, 0, 0, "R9 not authentic");
    send(mk(k1, 0, 0), 128'hA5A5, 0, 1, 0, 0, "R10 recover");
    chk(q.size() == 0, "R12 all completions seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule